// File: doc/BRIEF.md
# Program Counter Sequencer Unit

This block owns the program counter of a small 8-bit accumulator processor and decides, slot by slot, where the next instruction comes from. The counter is 16 bits wide and is held as a high byte and a low byte. Each slot carries one decoded operation. The unit can step the counter for straight-line fetch, add a signed byte offset, load an absolute target, or replace only the low byte with a table byte. It can also load a two-byte service vector, call and return through an internal return stack, and carry out conditional skips.

The instruction decoder presents one operation per slot on `opCode`, qualified by `opValid`, together with a 16-bit operand on `opTarget`, the accumulator on `accIn` and a test outcome on `condTrue`. The unit drives `pmAddr` toward program memory and expects the addressed byte back on `pmRdData` within the same cycle. A skipped slot still takes a cycle and advances the counter by one. Its operation is discarded, and `skipNow` flags that slot. A vector load takes two cycles, and `busy` marks the second one.

Top module: `pcSeqUnit`

## Requirements
- R1: A synchronous active-high `rst` sets `pcOut` to 0000h, empties the return stack, clears any pending skip, clears `stackErr` and leaves `busy` low.
- R2: Opcode 0 (sequential), and any opcode value above 8, increments the whole 16-bit counter with carry from the low byte into the high byte (00FFh becomes 0100h, FFFFh becomes 0000h).
- R3: Opcode 1 (relative) loads the counter with the address of the next instruction (pc+1) plus `opTarget[7:0]` taken as a signed two's-complement byte.
- R4: Opcode 2 (absolute) loads the counter with `opTarget`.
- R5: Opcode 3 (indirect) drives `pmAddr` with {counter high byte, `accIn`} in that cycle and loads the returned byte into the counter's low byte only. For example, high byte 01h, accumulator 26h and memory 0126h holding 32h give 0132h.
- R6: Opcode 8 (vector) reads the high byte at `pmAddr`=`opTarget` in its own cycle. In the following cycle `busy` is high and the low byte is read at `opTarget`+1. The counter keeps its value until the end of that second cycle and then takes {high, low}. Any operation presented while `busy` is high is ignored.
- R7: Opcode 4 (call) pushes pc+1 onto the return stack and loads `opTarget`. Opcode 5 (return) pops the most recent entry into the counter.
- R8: Opcode 6 (return-and-skip) pops like a return, and the slot at the restored address is then skipped.
- R9: Opcode 7 (test) advances the counter by one. When `condTrue` is 0, the next slot is skipped: `skipNow` is high during it, its operation has no effect and the counter advances by one. When `condTrue` is 1, nothing is skipped.
- R10: The return stack holds 8 entries. A ninth push overwrites the oldest entry and sets `stackErr`. A pop from an empty stack sets `stackErr` and loads 0000h. `stackErr` stays set until reset.
- R11: While `opValid` is low and `busy` is low, the counter, the stack and any pending skip are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | A decoded operation is present this slot |
| opCode | input | 4 | Decoded operation code (see requirements) |
| opTarget | input | 16 | Absolute target, vector address, or signed offset in bits 7:0 |
| accIn | input | 8 | Accumulator value, used as table index for indirect jumps |
| condTrue | input | 1 | Outcome of the test operation |
| pmRdData | input | 8 | Program-memory byte at `pmAddr`, valid in the same cycle |
| pmAddr | output | 16 | Program-memory read address |
| pcOut | output | 16 | Current program counter |
| busy | output | 1 | Second cycle of a vector load; operations are ignored |
| skipNow | output | 1 | The current slot is being skipped |
| stackErr | output | 1 | Sticky return-stack overflow or underflow flag |

## Verification
The assertions assume that program memory answers within the same cycle, so the byte on `pmRdData` belongs to the address the unit is driving. They also assume that the decoder changes `opCode` and `opTarget` only between clock edges. The stimulus meets both conditions: a combinational memory model in the bench computes each byte from its address, and every operation is driven at the falling edge. During the busy cycle of a vector load, the bench deliberately presents an absolute jump to show that it is ignored. Overflow and underflow are reached only by explicit call and return runs, so the stack-count bound always holds.

// File: rtl/pcsq_pkg.sv
package pcsq_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OPC_SEQ   = 4'd0;
  localparam logic [OPW-1:0] OPC_JREL  = 4'd1;
  localparam logic [OPW-1:0] OPC_JABS  = 4'd2;
  localparam logic [OPW-1:0] OPC_JIND  = 4'd3;
  localparam logic [OPW-1:0] OPC_CALL  = 4'd4;
  localparam logic [OPW-1:0] OPC_RET   = 4'd5;
  localparam logic [OPW-1:0] OPC_RETSK = 4'd6;
  localparam logic [OPW-1:0] OPC_TEST  = 4'd7;
  localparam logic [OPW-1:0] OPC_VECT  = 4'd8;

  typedef enum logic [2:0] {
    PC_HOLD, PC_INC, PC_REL, PC_ABS, PC_IND, PC_VEC, PC_POP
  } pcSel_e;

  typedef enum logic [1:0] {
    ADR_PC, ADR_IND, ADR_VHI, ADR_VLO
  } adrSel_e;

  typedef struct packed {
    pcSel_e  pcSel;
    adrSel_e adrSel;
    logic    push;
    logic    pop;
    logic    vecLatch;
  } strobe_t;
endpackage

// File: rtl/pcsqCtrl.sv
module pcsqCtrl
  import pcsq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           opValid,
  input  logic [OPW-1:0] opCode,
  input  logic           condTrue,
  output strobe_t        str,
  output logic           busy,
  output logic           skipNow
);
  typedef enum logic {ST_RUN, ST_VEC2} state_e;

  state_e state, nextState;
  logic   skipReg, nextSkip;

  always_comb begin
    str       = '{pcSel: PC_HOLD, adrSel: ADR_PC, push: 1'b0, pop: 1'b0, vecLatch: 1'b0};
    nextState = state;
    nextSkip  = skipReg;
    if (state == ST_VEC2) begin
      str.pcSel  = PC_VEC;
      str.adrSel = ADR_VLO;
      nextState  = ST_RUN;
    end else if (opValid) begin
      if (skipReg) begin
        str.pcSel = PC_INC;
        nextSkip  = 1'b0;
      end else begin
        case (opCode)
          OPC_JREL: str.pcSel = PC_REL;
          OPC_JABS: str.pcSel = PC_ABS;
          OPC_JIND: begin
            str.pcSel  = PC_IND;
            str.adrSel = ADR_IND;
          end
          OPC_CALL: begin
            str.pcSel = PC_ABS;
            str.push  = 1'b1;
          end
          OPC_RET: begin
            str.pcSel = PC_POP;
            str.pop   = 1'b1;
          end
          OPC_RETSK: begin
            str.pcSel = PC_POP;
            str.pop   = 1'b1;
            nextSkip  = 1'b1;
          end
          OPC_TEST: begin
            str.pcSel = PC_INC;
            nextSkip  = !condTrue;
          end
          OPC_VECT: begin
            str.adrSel   = ADR_VHI;
            str.vecLatch = 1'b1;
            nextState    = ST_VEC2;
          end
          default: str.pcSel = PC_INC;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RUN;
      skipReg <= 1'b0;
    end else begin
      state   <= nextState;
      skipReg <= nextSkip;
    end
  end

  assign busy    = (state == ST_VEC2);
  assign skipNow = skipReg && (state == ST_RUN);

  AST_VEC_ONE_EXTRA: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);  // R6
  AST_SKIP_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (skipNow && opValid) |=> !skipNow);  // R9
  AST_IDLE_KEEPS_SKIP: assert property (@(posedge clk) disable iff (rst)
    (!opValid && !busy) |=> (skipNow == $past(skipNow)));  // R11
endmodule

// File: rtl/pcsqStack.sv
module pcsqStack #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] pushData,
  output logic [ADDR_W-1:0] popData,
  output logic              err
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CNT_W = PW + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [PW-1:0]    LAST = PW'(DEPTH - 1);

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp;
  logic [PW-1:0]     topIdx;
  logic [PW-1:0]     wpNext;
  logic [CNT_W-1:0]  cnt;
  logic              empty;

  assign empty   = (cnt == '0);
  assign topIdx  = (wp == '0) ? LAST : wp - 1'b1;
  assign wpNext  = (wp == LAST) ? '0 : wp + 1'b1;
  assign popData = empty ? '0 : mem[topIdx];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      cnt <= '0;
      err <= 1'b0;
    end else if (push) begin
      wp <= wpNext;
      if (cnt == FULL) err <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end else if (pop) begin
      if (empty) begin
        err <= 1'b1;
      end else begin
        wp  <= topIdx;
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);  // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err);  // R10
  AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (push && cnt == FULL) |=> err);  // R10
  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));  // R7
endmodule

// File: rtl/pcsqPath.sv
module pcsqPath
  import pcsq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               str,
  input  logic [2*DATA_W-1:0]   opTarget,
  input  logic [DATA_W-1:0]     accIn,
  input  logic [DATA_W-1:0]     pmRdData,
  input  logic [2*DATA_W-1:0]   popData,
  output logic [2*DATA_W-1:0]   pmAddr,
  output logic [2*DATA_W-1:0]   pc,
  output logic [2*DATA_W-1:0]   pcInc
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] relTgt;
  logic [ADDR_W-1:0] pcNext;
  logic [ADDR_W-1:0] vecBase;
  logic [DATA_W-1:0] vecHi;
  logic [DATA_W-1:0] pcHigh;

  assign pcHigh = pc[ADDR_W-1:DATA_W];
  assign pcInc  = pc + 1'b1;
  assign relTgt = pcInc + {{DATA_W{opTarget[DATA_W-1]}}, opTarget[DATA_W-1:0]};

  always_comb begin
    case (str.adrSel)
      ADR_IND: pmAddr = {pcHigh, accIn};
      ADR_VHI: pmAddr = opTarget;
      ADR_VLO: pmAddr = vecBase + 1'b1;
      default: pmAddr = pc;
    endcase
  end

  always_comb begin
    case (str.pcSel)
      PC_INC:  pcNext = pcInc;
      PC_REL:  pcNext = relTgt;
      PC_ABS:  pcNext = opTarget;
      PC_IND:  pcNext = {pcHigh, pmRdData};
      PC_VEC:  pcNext = {vecHi, pmRdData};
      PC_POP:  pcNext = popData;
      default: pcNext = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      vecBase <= '0;
      vecHi   <= '0;
    end else begin
      pc <= pcNext;
      if (str.vecLatch) begin
        vecBase <= opTarget;
        vecHi   <= pmRdData;
      end
    end
  end

  AST_IND_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (str.pcSel == PC_IND) |=> (pc[ADDR_W-1:DATA_W] == $past(pc[ADDR_W-1:DATA_W])));  // R5
  AST_INC_STEPS_ONE: assert property (@(posedge clk) disable iff (rst)
    (str.pcSel == PC_INC) |=> (pc == $past(pc) + 1'b1));  // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (str.pcSel == PC_HOLD) |=> $stable(pc));  // R11
endmodule

// File: rtl/pcSeqUnit.sv
module pcSeqUnit
  import pcsq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                opValid,
  input  logic [OPW-1:0]      opCode,
  input  logic [2*DATA_W-1:0] opTarget,
  input  logic [DATA_W-1:0]   accIn,
  input  logic                condTrue,
  input  logic [DATA_W-1:0]   pmRdData,
  output logic [2*DATA_W-1:0] pmAddr,
  output logic [2*DATA_W-1:0] pcOut,
  output logic                busy,
  output logic                skipNow,
  output logic                stackErr
);
  localparam int ADDR_W = 2 * DATA_W;

  strobe_t           str;
  logic [ADDR_W-1:0] pcInc;
  logic [ADDR_W-1:0] popData;

  pcsqCtrl uCtrl (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .condTrue(condTrue), .str(str), .busy(busy), .skipNow(skipNow)
  );

  pcsqPath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rst(rst), .str(str), .opTarget(opTarget), .accIn(accIn),
    .pmRdData(pmRdData), .popData(popData), .pmAddr(pmAddr),
    .pc(pcOut), .pcInc(pcInc)
  );

  pcsqStack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) uStack (
    .clk(clk), .rst(rst), .push(str.push), .pop(str.pop),
    .pushData(pcInc), .popData(popData), .err(stackErr)
  );
endmodule

// File: tb/sim_pcSeqUnit.sv
module sim_pcSeqUnit;
  import pcsq_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [15:0] opTarget = 16'h0;
  logic [7:0]  accIn = 8'h0;
  logic        condTrue = 1'b1;
  logic [7:0]  pmRdData;
  logic [15:0] pmAddr, pcOut;
  logic        busy, skipNow, stackErr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  typedef struct {
    logic [15:0] pc;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] pmFn(input logic [15:0] a);
    if (a == 16'h0126) return 8'h32;
    return (a[7:0] ^ a[15:8]) + 8'h11;
  endfunction

  assign pmRdData = pmFn(pmAddr);

  pcSeqUnit u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .opTarget(opTarget), .accIn(accIn), .condTrue(condTrue),
    .pmRdData(pmRdData), .pmAddr(pmAddr), .pcOut(pcOut),
    .busy(busy), .skipNow(skipNow), .stackErr(stackErr)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected counter value after each driven edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(pcOut == e.pc, e.tag, pcOut, e.pc);
      end
    end
  end

  // driver: presents one slot and queues the counter value expected after it
  task automatic issue(input logic [3:0] c, input logic [15:0] t, input logic [7:0] a,
                       input bit cond, input bit v, input logic [15:0] expPc, input string tag);
    @(negedge clk);
    opCode = c; opTarget = t; accIn = a; condTrue = cond; opValid = v;
    expQ.push_back('{expPc, tag});
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
  endtask

  task automatic op(input logic [3:0] c, input logic [15:0] t, input logic [15:0] expPc, input string tag);
    issue(c, t, 8'h00, 1'b1, 1'b1, expPc, tag);
    tick();
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; opValid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    check(pcOut == 16'h0000, "R1 reset pc", pcOut, 16'h0000);
    check({busy, skipNow, stackErr} == 3'b000, "R1 reset flags", {13'h0, busy, skipNow, stackErr}, 16'h0);

    op(OPC_SEQ, 16'h0, 16'h0001, "R2 step");
    op(OPC_JABS, 16'h00FF, 16'h00FF, "R4 absolute");
    op(OPC_SEQ, 16'h0, 16'h0100, "R2 low-byte carry");
    op(OPC_JABS, 16'hFFFF, 16'hFFFF, "R4 absolute top");
    op(4'd13, 16'h0, 16'h0000, "R2 unknown opcode wraps");

    op(OPC_JREL, 16'h0010, 16'h0011, "R3 forward offset");
    op(OPC_JREL, 16'h00F0, 16'h0002, "R3 backward offset");

    op(OPC_JABS, 16'h0150, 16'h0150, "R4 absolute");
    issue(OPC_JIND, 16'h0, 8'h26, 1'b1, 1'b1, 16'h0132, "R5 indirect result");
    check(pmAddr == 16'h0126, "R5 indirect table address", pmAddr, 16'h0126);
    tick();

    issue(OPC_VECT, 16'h00F0, 8'h00, 1'b1, 1'b1, 16'h0132, "R6 vector holds pc");
    check(pmAddr == 16'h00F0, "R6 vector high address", pmAddr, 16'h00F0);
    tick();
    issue(OPC_JABS, 16'h1111, 8'h00, 1'b1, 1'b1, {pmFn(16'h00F0), pmFn(16'h00F1)}, "R6 vector load");
    check(busy == 1'b1, "R6 busy second cycle", {15'h0, busy}, 16'h1);
    check(pmAddr == 16'h00F1, "R6 vector low address", pmAddr, 16'h00F1);
    tick();
    #1;
    check(busy == 1'b0, "R6 busy clears", {15'h0, busy}, 16'h0);

    op(OPC_CALL, 16'h0300, 16'h0300, "R7 call");
    op(OPC_CALL, 16'h0400, 16'h0400, "R7 nested call");
    op(OPC_RET, 16'h0, 16'h0301, "R7 return inner");
    op(OPC_RET, 16'h0, 16'h0103, "R7 return outer");

    op(OPC_CALL, 16'h0500, 16'h0500, "R8 call");
    op(OPC_RETSK, 16'h0, 16'h0104, "R8 return-and-skip");
    issue(OPC_JABS, 16'h1234, 8'h00, 1'b1, 1'b1, 16'h0105, "R8 skipped slot ignored");
    check(skipNow == 1'b1, "R8 skip flagged", {15'h0, skipNow}, 16'h1);
    tick();

    issue(OPC_TEST, 16'h0, 8'h00, 1'b0, 1'b1, 16'h0106, "R9 false test steps");
    tick();
    issue(OPC_CALL, 16'h2222, 8'h00, 1'b1, 1'b1, 16'h0107, "R9 skipped call ignored");
    check(skipNow == 1'b1, "R9 skip flagged", {15'h0, skipNow}, 16'h1);
    tick();
    issue(OPC_TEST, 16'h0, 8'h00, 1'b1, 1'b1, 16'h0108, "R9 true test steps");
    tick();
    issue(OPC_JABS, 16'h2000, 8'h00, 1'b1, 1'b1, 16'h2000, "R9 no skip after true");
    check(skipNow == 1'b0, "R9 no skip flag", {15'h0, skipNow}, 16'h0);
    tick();

    issue(OPC_JABS, 16'h7777, 8'h00, 1'b1, 1'b0, 16'h2000, "R11 idle holds");
    tick();
    issue(OPC_RET, 16'h0, 8'h00, 1'b1, 1'b0, 16'h2000, "R11 idle holds again");
    tick();

    for (int i = 0; i < 9; i++) begin
      if (i == 8) begin
        #1;
        check(stackErr == 1'b0, "R10 full stack no error", {15'h0, stackErr}, 16'h0);
      end
      op(OPC_CALL, 16'h3000 + 16'(i), 16'h3000 + 16'(i), "R10 call run");
    end
    #1;
    check(stackErr == 1'b1, "R10 overflow flag", {15'h0, stackErr}, 16'h1);
    for (int i = 0; i < 8; i++) begin
      op(OPC_RET, 16'h0, 16'h3008 - 16'(i), "R10 pop after overflow");
    end
    op(OPC_RET, 16'h0, 16'h0000, "R10 underflow loads zero");
    #1;
    check(stackErr == 1'b1, "R10 flag sticky", {15'h0, stackErr}, 16'h1);

    op(OPC_JABS, 16'h4444, 16'h4444, "R4 absolute");
    doReset();
    check(pcOut == 16'h0000, "R1 reset clears pc", pcOut, 16'h0000);
    check(stackErr == 1'b0, "R1 reset clears error", {15'h0, stackErr}, 16'h0);
    op(OPC_RET, 16'h0, 16'h0000, "R1 stack empty after reset");

    repeat (3) @(posedge clk);
    #1;
    check(expQ.size() == 0, "queue drained", 16'(expQ.size()), 16'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule